// File: doc/BRIEF.md
# Banked CPU Register File

This block is the architectural register store of a CISC processor core. It keeps sixteen 32-bit general registers under one linear index: indices 0 to 7 are the data registers and 8 to 15 the address registers. It also keeps a program counter, a 16-bit status word and one shadow stack-pointer register. Index 15 is always the stack pointer of the current privilege mode. The shadow register holds the stack pointer of the other mode.

Writes carry a size code. A byte or word write merges into the low bits of the target register, and the rest of the register keeps its value. Reads carry a size code too and return the value masked to that width. When a status-word load changes the supervisor bit (bit 13), register 15 and the shadow register exchange contents in that same cycle. The exchange happens before any register write in the same cycle, so a write to index 15 lands in the stack pointer of the mode being entered.

Top module: `banked_regfile`

## Requirements
- R1: All sixteen registers are addressed by one 4-bit index. A long write to index i appears on either read port from the cycle after the write edge. Before that edge the read ports still show the old contents.
- R2: A byte write (size code 2'b00) replaces bits 7:0 of the target register. Bits 31:8 keep their previous value.
- R3: A word write (size code 2'b01) replaces bits 15:0 of the target register. Bits 31:16 keep their previous value. A long write (size code 2'b10) replaces all 32 bits.
- R4: A read with size code 2'b00 returns bits 7:0 with zero above them. Size code 2'b01 returns bits 15:0 with zero above them. Size codes 2'b10 and 2'b11 return the full 32 bits.
- R5: A status-word load whose bit 13 equals the current bit 13 updates the status word. It leaves register 15 and the shadow register unchanged.
- R6: A status-word load whose bit 13 differs from the current bit 13 exchanges register 15 and the shadow register in the same cycle.
- R7: A write with size code 2'b11 leaves every register unchanged.
- R8: If a write to index 15 coincides with a load that exchanges the stack pointers, the exchange happens first. The write then merges into the value the shadow register held, and the shadow register takes the old register 15.
- R9: Reset clears all sixteen registers, the shadow register and the program counter to zero, and sets the status word to 0x2000.
- R10: A program-counter load replaces the program counter from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 4 | Register index for read port A |
| rd_a_size | input | 2 | Size code for read port A |
| rd_a_data | output | 32 | Masked read data, port A |
| rd_b_idx | input | 4 | Register index for read port B |
| rd_b_size | input | 2 | Size code for read port B |
| rd_b_data | output | 32 | Masked read data, port B |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register index for the write |
| wr_size | input | 2 | Size code for the write |
| wr_data | input | 32 | Write data; only the low bits for the size are used |
| sr_load | input | 1 | Status-word load strobe |
| sr_data | input | 16 | New status word |
| sr_q | output | 16 | Current status word |
| pc_load | input | 1 | Program-counter load strobe |
| pc_data | input | 32 | New program counter |
| pc_q | output | 32 | Current program counter |
| alt_sp_q | output | 32 | Current shadow stack pointer |

## Verification
The merge-preservation properties assume no exchange is in flight for the written index. They are guarded on that, because a coinciding exchange changes the base value that the write merges into. The exchange properties assume no write to index 15 in the same cycle, and the unchanged-file property assumes no exchange in that cycle. The bench drives each strobe on the falling edge and keeps every other strobe low. Only the coincidence scenario for R8 raises the write and the status load together, and that case is checked against a value the bench computes itself.

// File: rtl/rf_pkg.sv
package rf_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_BAD  = 2'b11
    } size_e;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

endpackage

// File: rtl/rf_merge.sv
module rf_merge #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]     old_val,
    input  logic [DW-1:0]     new_val,
    input  rf_pkg::size_e     size,
    output logic [DW-1:0]     merged,
    output logic              legal
);
    import rf_pkg::*;

    always_comb begin
        merged = old_val;
        legal  = 1'b1;
        case (size)
            SZ_BYTE: merged[BYTE_W-1:0] = new_val[BYTE_W-1:0];
            SZ_WORD: merged[WORD_W-1:0] = new_val[WORD_W-1:0];
            SZ_LONG: merged = new_val;
            default: legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/rf_read_mask.sv
module rf_read_mask #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] raw,
    input  rf_pkg::size_e size,
    output logic [DW-1:0] data
);
    import rf_pkg::*;

    always_comb begin
        data = raw;
        case (size)
            SZ_BYTE: data = {{(DW-BYTE_W){1'b0}}, raw[BYTE_W-1:0]};
            SZ_WORD: data = {{(DW-WORD_W){1'b0}}, raw[WORD_W-1:0]};
            default: data = raw;
        endcase
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile #(
    parameter int          DW       = 32,
    parameter int          NREG     = 16,
    parameter int          SRW      = 16,
    parameter int          SWAP_BIT = 13,
    parameter logic [15:0] SR_RESET = 16'h2000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(NREG)-1:0]   rd_a_idx,
    input  logic [1:0]                rd_a_size,
    output logic [DW-1:0]             rd_a_data,
    input  logic [$clog2(NREG)-1:0]   rd_b_idx,
    input  logic [1:0]                rd_b_size,
    output logic [DW-1:0]             rd_b_data,
    input  logic                      wr_en,
    input  logic [$clog2(NREG)-1:0]   wr_idx,
    input  logic [1:0]                wr_size,
    input  logic [DW-1:0]             wr_data,
    input  logic                      sr_load,
    input  logic [SRW-1:0]            sr_data,
    output logic [SRW-1:0]            sr_q,
    input  logic                      pc_load,
    input  logic [DW-1:0]             pc_data,
    output logic [DW-1:0]             pc_q,
    output logic [DW-1:0]             alt_sp_q
);
    import rf_pkg::*;

    localparam int             IW     = $clog2(NREG);
    localparam int             NPORT  = 2;
    localparam logic [IW-1:0]  SP_IDX = IW'(NREG - 1);

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
        logic [DW-1:0]           shadow;
        logic [DW-1:0]           pc;
        logic [SRW-1:0]          sr;
    } state_t;

    state_t  st_q, mid_d, st_d;
    logic    swap_d;
    logic [DW-1:0] wr_base_d, wr_merged_d;
    logic          wr_legal_d;

    // stage 1: status load, stack-pointer exchange, program counter
    always_comb begin
        mid_d  = st_q;
        swap_d = sr_load && (sr_data[SWAP_BIT] != st_q.sr[SWAP_BIT]);
        if (sr_load) mid_d.sr = sr_data;
        if (swap_d) begin
            mid_d.regs[SP_IDX] = st_q.shadow;
            mid_d.shadow       = st_q.regs[SP_IDX];
        end
        if (pc_load) mid_d.pc = pc_data;
    end

    assign wr_base_d = mid_d.regs[wr_idx];

    rf_merge #(.DW(DW)) u_merge (
        .old_val (wr_base_d),
        .new_val (wr_data),
        .size    (size_e'(wr_size)),
        .merged  (wr_merged_d),
        .legal   (wr_legal_d)
    );

    // stage 2: sized register write on top of the exchanged state
    always_comb begin
        st_d = mid_d;
        if (wr_en && wr_legal_d) st_d.regs[wr_idx] = wr_merged_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.sr     <= SR_RESET[SRW-1:0];
        end else begin
            st_q        <= st_d;
        end
    end

    // read ports
    logic [NPORT-1:0][IW-1:0] rd_idx;
    logic [NPORT-1:0][1:0]    rd_size;
    logic [NPORT-1:0][DW-1:0] rd_out;

    assign rd_idx  = {rd_b_idx, rd_a_idx};
    assign rd_size = {rd_b_size, rd_a_size};

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        rf_read_mask #(.DW(DW)) u_mask (
            .raw  (st_q.regs[rd_idx[p]]),
            .size (size_e'(rd_size[p])),
            .data (rd_out[p])
        );
    end

    assign rd_a_data = rd_out[0];
    assign rd_b_data = rd_out[1];
    assign sr_q      = st_q.sr;
    assign pc_q      = st_q.pc;
    assign alt_sp_q  = st_q.shadow;

    // checks
    a_r2_byte_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 2'b00 && !(swap_d && wr_idx == SP_IDX))
        |=> st_q.regs[$past(wr_idx)][DW-1:BYTE_W] == $past(st_q.regs[wr_idx][DW-1:BYTE_W]));

    a_r3_word_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 2'b01 && !(swap_d && wr_idx == SP_IDX))
        |=> st_q.regs[$past(wr_idx)][DW-1:WORD_W] == $past(st_q.regs[wr_idx][DW-1:WORD_W]));

    a_r6_sp_exchange: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_load && sr_data[SWAP_BIT] != sr_q[SWAP_BIT] && !(wr_en && wr_idx == SP_IDX))
        |=> (alt_sp_q == $past(st_q.regs[SP_IDX])) && (st_q.regs[SP_IDX] == $past(alt_sp_q)));

    a_r5_no_exchange: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_load && sr_data[SWAP_BIT] == sr_q[SWAP_BIT]) |=> $stable(alt_sp_q));

    a_r7_bad_size_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 2'b11 && !sr_load) |=> $stable(st_q.regs));

    always_comb begin
        if (rst_n) begin
            a_r4_byte_read_masked: assert (rd_a_size != 2'b00 || rd_a_data[DW-1:BYTE_W] == '0);
        end
    end

endmodule

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [1:0]  rd_a_size, rd_b_size, wr_size;
    logic [31:0] rd_a_data, rd_b_data, wr_data, pc_data, pc_q, alt_sp_q;
    logic        wr_en, sr_load, pc_load;
    logic [15:0] sr_data, sr_q;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_regfile u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_size(rd_a_size), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_size(rd_b_size), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_data(wr_data),
        .sr_load(sr_load), .sr_data(sr_data), .sr_q(sr_q),
        .pc_load(pc_load), .pc_data(pc_data), .pc_q(pc_q),
        .alt_sp_q(alt_sp_q)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_idx = 0; wr_size = 2'b10; wr_data = 0;
        sr_load = 0; sr_data = 0; pc_load = 0; pc_data = 0;
    endtask

    // drive on falling edge, let it register, sample after the edge
    task automatic commit();
        @(posedge clk);
        #1;
        @(negedge clk);
        idle();
    endtask

    task automatic wr(logic [3:0] i, logic [1:0] s, logic [31:0] d);
        wr_en = 1; wr_idx = i; wr_size = s; wr_data = d;
        commit();
    endtask

    task automatic sr_ld(logic [15:0] v);
        sr_load = 1; sr_data = v;
        commit();
    endtask

    task automatic rd_a(logic [3:0] i, logic [1:0] s, output logic [31:0] v);
        rd_a_idx = i; rd_a_size = s; #1; v = rd_a_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 16; i++) begin
            rd_a(4'(i), 2'b10, v);
            chk("R9 reg clear", v, 0);
        end
        chk("R9 sr reset", {16'h0, sr_q}, 32'h2000);
        chk("R9 shadow clear", alt_sp_q, 0);
        chk("R9 pc clear", pc_q, 0);
    endtask

    task automatic t_long_write();
        logic [31:0] v;
        wr_en = 1; wr_idx = 3; wr_size = 2'b10; wr_data = 32'h11223344;
        rd_b_idx = 3; rd_b_size = 2'b10; #1;
        chk("R1 old value before edge", rd_b_data, 0);
        commit();
        rd_b_idx = 3; #1;
        chk("R1 long write port B", rd_b_data, 32'h11223344);
        wr(4'd12, 2'b10, 32'hCAFE0012);
        rd_a(4'd12, 2'b10, v);
        chk("R1 address reg port A", v, 32'hCAFE0012);
        rd_a(4'd3, 2'b10, v);
        chk("R1 neighbour untouched", v, 32'h11223344);
    endtask

    task automatic t_byte_write();
        logic [31:0] v;
        wr(4'd3, 2'b00, 32'hFFFFFF55);
        rd_a(4'd3, 2'b10, v);
        chk("R2 byte merge", v, 32'h11223355);
    endtask

    task automatic t_word_write();
        logic [31:0] v;
        wr(4'd3, 2'b01, 32'h9999BEEF);
        rd_a(4'd3, 2'b10, v);
        chk("R3 word merge", v, 32'h1122BEEF);
    endtask

    task automatic t_read_mask();
        logic [31:0] v;
        rd_a(4'd3, 2'b00, v);
        chk("R4 byte read", v, 32'h000000EF);
        rd_a(4'd3, 2'b01, v);
        chk("R4 word read", v, 32'h0000BEEF);
        rd_a(4'd3, 2'b11, v);
        chk("R4 code 11 read full", v, 32'h1122BEEF);
        rd_b_idx = 12; rd_b_size = 2'b01; #1;
        chk("R4 word read port B", rd_b_data, 32'h00000012);
    endtask

    task automatic t_bad_size();
        logic [31:0] v;
        wr(4'd3, 2'b11, 32'h0);
        rd_a(4'd3, 2'b10, v);
        chk("R7 bad size ignored", v, 32'h1122BEEF);
    endtask

    task automatic t_exchange();
        logic [31:0] v;
        wr(4'd15, 2'b10, 32'h00001000);
        sr_ld(16'h0000);
        rd_a(4'd15, 2'b10, v);
        chk("R6 leave supervisor sp", v, 32'h0);
        chk("R6 shadow takes sp", alt_sp_q, 32'h00001000);
        sr_ld(16'h2700);
        rd_a(4'd15, 2'b10, v);
        chk("R6 return sp", v, 32'h00001000);
        chk("R6 shadow back", alt_sp_q, 32'h0);
    endtask

    task automatic t_same_mode();
        logic [31:0] v;
        sr_ld(16'h2704);
        rd_a(4'd15, 2'b10, v);
        chk("R5 sp unchanged", v, 32'h00001000);
        chk("R5 shadow unchanged", alt_sp_q, 32'h0);
        chk("R5 sr loaded", {16'h0, sr_q}, 32'h2704);
    endtask

    task automatic t_coincide();
        logic [31:0] v;
        wr_en = 1; wr_idx = 15; wr_size = 2'b01; wr_data = 32'h5555ABCD;
        sr_load = 1; sr_data = 16'h0004;
        commit();
        rd_a(4'd15, 2'b10, v);
        chk("R8 write lands in new sp", v, 32'h0000ABCD);
        chk("R8 shadow holds old sp", alt_sp_q, 32'h00001000);
    endtask

    task automatic t_pc();
        pc_load = 1; pc_data = 32'h00FF0010;
        commit();
        chk("R10 pc load", pc_q, 32'h00FF0010);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        idle();
        rd_a_idx = 0; rd_a_size = 2'b10; rd_b_idx = 0; rd_b_size = 2'b10;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_long_write();
        t_byte_write();
        t_word_write();
        t_read_mask();
        t_bad_size();
        t_exchange();
        t_same_mode();
        t_coincide();
        t_pc();
        summary();
    end

endmodule